// File: doc/BRIEF.md
# SDRAM Device-Side Command Tracker

This block models the command side of a single-data-rate SDRAM device. On every rising clock edge where the clock enable is high, it samples the chip select, the three active-low strobes, the two bank-select bits, the twelve address bits and the two byte masks. It decodes each command and keeps an open/idle flag and the open row for each of four banks. It also runs read and write bursts, applies automatic precharge when a burst ends, and produces per-byte write enables and read output enables with the mask latency each direction requires.

Each burst beat drives a small storage-access port. The port carries the bank, the open row and the sequentially stepped column, so a small behavioural array can serve the data. If the command stream breaks the bank protocol, a sticky error flag is set and the offending command has no effect.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, all banks are idle, the error flag is low, no access is active and both strobe pairs are zero. The default mode is a burst of 1 with read latency 2.
- R2: A command is decoded only when `cke`=1 and `cs_n`=0. With {ras_n,cas_n,we_n}: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh (no bank effect), 000 mode set. A deselected cycle changes no bank state.
- R3: Activate opens bank `ba` and stores `addr` as its row. Every later access to that bank reports that row on `acc_row`.
- R4: Mode set latches the burst length from `addr[1:0]` (0,1,2,3 give 1,2,4,8 beats). It latches read latency 3 when `addr[6:4]`=3, and latency 2 otherwise.
- R5: A read or write to an open bank, sampled at edge t, raises `acc_rd` or `acc_wr` after edges t to t+BL-1. The first beat uses column `addr[8:0]`. The low log2(BL) column bits then count up and wrap inside the aligned BL block, while the upper bits hold.
- R6: After the edge of each write beat, `wr_en` equals the inverse of `dqm` sampled on that same edge (zero latency). Otherwise `wr_en` is 0.
- R7: Read beat k of a read at edge t is due at edge t+CL+k. `rd_oe` is high in the cycle before that edge, for bytes whose `dqm` was low at edge t+CL+k-2 (two-cycle latency). Otherwise `rd_oe` is 0.
- R8: A read or write with `addr[10]`=1 closes its bank at edge t+BL. With `addr[10]`=0, the bank stays open.
- R9: Precharge with `addr[10]`=1 closes all banks. With `addr[10]`=0, it closes only bank `ba`.
- R10: A read or write to an idle bank starts no burst. An activate to an open bank leaves its row unchanged. Either one sets `proto_err`, which stays high until reset.
- R11: An edge with `cke`=0 changes no state: bank flags, rows, burst position and strobes all hold, and any command on the pins is ignored.
- R12: A burst already running continues through cycles where `cs_n` is high, whatever the strobe pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes all state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column, mode and bit-10 precharge control |
| dqm | input | 2 | Per-byte mask, high blocks the byte |
| bank_open | output | 4 | One flag per bank, high when open |
| proto_err | output | 1 | Sticky protocol error |
| acc_rd | output | 1 | Read beat issued to storage |
| acc_wr | output | 1 | Write beat issued to storage |
| acc_bank | output | 2 | Bank of the current beat |
| acc_row | output | 12 | Open row of that bank |
| acc_col | output | 9 | Column of the current beat |
| wr_en | output | 2 | Per-byte write enable for the current beat |
| rd_oe | output | 2 | Per-byte read output enable |

## Verification
Bank flags, the error flag, the access port and `wr_en` are all due in the cycle after the edge that sampled the stimulus. The bench therefore drives each command at a falling edge and compares at the next falling edge. For read output enables, the bench derives each expected value from the beat index and latency: beat k of a read at edge t is checked in the cycle after edge t+CL+k-1, against the mask driven two edges earlier. The near-exhaustive sweep covers every burst length, both latencies, both auto-precharge settings, several start columns and both directions, with a mask pattern that differs per cycle. Auto-precharge closure is checked at exactly the cycle after edge t+BL.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int NBANK  = 4,
  parameter int BYTES  = 2,
  parameter int AP_BIT = 10
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [$clog2(NBANK)-1:0] ba,
  input  logic [ROW_W-1:0]         addr,
  input  logic [BYTES-1:0]         dqm,
  output logic [NBANK-1:0]         bank_open,
  output logic                     proto_err,
  output logic                     acc_rd,
  output logic                     acc_wr,
  output logic [$clog2(NBANK)-1:0] acc_bank,
  output logic [ROW_W-1:0]         acc_row,
  output logic [COL_W-1:0]         acc_col,
  output logic [BYTES-1:0]         wr_en,
  output logic [BYTES-1:0]         rd_oe
);
  localparam int BA_W  = $clog2(NBANK);
  localparam int CNT_W = 3;

  logic [2:0]       cmd;
  logic             sel, do_act, do_rd, do_wr, do_pre, do_mrs;
  logic             hit, start, cont, wbeat;
  logic [NBANK-1:0] open_q, open_nxt;
  logic [ROW_W-1:0] row_q [NBANK];
  logic [1:0]       bl_code;
  logic             cl3;
  logic             busy_q, wr_q, ap_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q, col_step;
  logic [CNT_W-1:0] left_q, mask_q, bl_mask, lo_inc;
  logic [BYTES-1:0] wr_en_q, dqm_q1, dqm_q2;
  logic             rv1, rv2;

  assign sel    = cke & ~cs_n;
  assign cmd    = {ras_n, cas_n, we_n};
  assign do_act = sel && cmd == 3'b011;
  assign do_rd  = sel && cmd == 3'b101;
  assign do_wr  = sel && cmd == 3'b100;
  assign do_pre = sel && cmd == 3'b010;
  assign do_mrs = sel && cmd == 3'b000;
  assign hit    = open_q[ba];
  assign start  = (do_rd | do_wr) & hit;
  assign cont   = busy_q && left_q != '0;
  assign wbeat  = start ? do_wr : (cont & wr_q);

  always_comb begin
    case (bl_code)
      2'd0:    bl_mask = 3'd0;
      2'd1:    bl_mask = 3'd1;
      2'd2:    bl_mask = 3'd3;
      default: bl_mask = 3'd7;
    endcase
  end

  assign lo_inc   = col_q[CNT_W-1:0] + 3'd1;
  assign col_step = {col_q[COL_W-1:CNT_W], (col_q[CNT_W-1:0] & ~mask_q) | (lo_inc & mask_q)};

  always_comb begin
    open_nxt = open_q;
    if (busy_q && left_q == '0 && ap_q) open_nxt[bank_q] = 1'b0;
    if (do_pre) begin
      if (addr[AP_BIT]) open_nxt = '0;
      else              open_nxt[ba] = 1'b0;
    end
    if (do_act && !hit) open_nxt[ba] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      proto_err <= 1'b0;
      bl_code   <= 2'd0;
      cl3       <= 1'b0;
      busy_q    <= 1'b0;
      wr_q      <= 1'b0;
      ap_q      <= 1'b0;
      bank_q    <= '0;
      col_q     <= '0;
      left_q    <= '0;
      mask_q    <= '0;
      wr_en_q   <= '0;
      rv1       <= 1'b0;
      rv2       <= 1'b0;
      dqm_q1    <= '0;
      dqm_q2    <= '0;
    end else if (cke) begin
      open_q <= open_nxt;
      if ((do_act && hit) || ((do_rd || do_wr) && !hit)) proto_err <= 1'b1;
      if (do_mrs) begin
        bl_code <= addr[1:0];
        cl3     <= addr[6:4] == 3'd3;
      end
      if (start) begin
        busy_q <= 1'b1;
        wr_q   <= do_wr;
        bank_q <= ba;
        col_q  <= addr[COL_W-1:0];
        left_q <= bl_mask;
        mask_q <= bl_mask;
        ap_q   <= addr[AP_BIT];
      end else if (busy_q) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 3'd1;
          col_q  <= col_step;
        end
      end
      wr_en_q <= wbeat ? ~dqm : '0;
      rv1     <= busy_q & ~wr_q;
      rv2     <= rv1;
      dqm_q1  <= dqm;
      dqm_q2  <= dqm_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_act && !hit) row_q[ba] <= addr;
  end

  assign bank_open = open_q;
  assign acc_rd    = busy_q & ~wr_q;
  assign acc_wr    = busy_q & wr_q;
  assign acc_bank  = bank_q;
  assign acc_row   = row_q[bank_q];
  assign acc_col   = col_q;
  assign wr_en     = wr_en_q;
  assign rd_oe     = (cl3 ? rv2 : rv1) ? ~dqm_q2 : '0;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int NBANK  = 4,
  parameter int BYTES  = 2,
  parameter int AP_BIT = 10
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cke,
  input logic                     cs_n,
  input logic                     ras_n,
  input logic                     cas_n,
  input logic                     we_n,
  input logic [$clog2(NBANK)-1:0] ba,
  input logic [ROW_W-1:0]         addr,
  input logic [BYTES-1:0]         dqm,
  input logic [NBANK-1:0]         bank_open,
  input logic                     proto_err,
  input logic                     acc_rd,
  input logic                     acc_wr,
  input logic [COL_W-1:0]         acc_col,
  input logic [BYTES-1:0]         wr_en,
  input logic [BYTES-1:0]         rd_oe
);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  a_r11_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_open) && $stable(acc_col) && $stable(proto_err) && $stable(wr_en));

  a_r2_deselect_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n && !acc_rd && !acc_wr) |=> $stable(bank_open));

  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && cas_n && we_n && !bank_open[ba]) |=> bank_open[$past(ba)]);

  a_r9_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT]) |=> bank_open == '0);

  a_r6_wr_mask_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && acc_wr) |-> wr_en == ~$past(dqm));

  a_r7_rd_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && $past(cke, 2) && !$past(acc_rd) && !$past(acc_rd, 2)) |-> rd_oe == '0);
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .NBANK(NBANK), .BYTES(BYTES), .AP_BIT(AP_BIT)
) i_chk (.*);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba, dqm;
  logic [11:0] addr;
  logic [3:0] bank_open;
  logic proto_err, acc_rd, acc_wr;
  logic [1:0] acc_bank, wr_en, rd_oe;
  logic [11:0] acc_row;
  logic [8:0] acc_col;
  int vec = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .bank_open(bank_open),
    .proto_err(proto_err), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_bank(acc_bank),
    .acc_row(acc_row), .acc_col(acc_col), .wr_en(wr_en), .rd_oe(rd_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] c, input logic [1:0] b, input logic [11:0] a);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setmode(input int blc, input int cl);
    cmd(C_MRS, 2'd0, {5'd0, 3'(cl), 2'd0, 2'(blc)}); step();
    cmd(C_PRE, 2'd0, 12'h400); step();
  endtask

  function automatic logic [1:0] pat(input int j, input int seed);
    return 2'(j * 3 + seed);
  endfunction

  task automatic run_burst(input int w, input int blc, input int cl, input int ap, input int c);
    int bl = 1 << blc;
    int msk = bl - 1;
    int seed = c + blc + ap;
    logic [1:0] bank = 2'((c + blc) & 3);
    logic [11:0] row = 12'h5A0 ^ 12'((blc << 4) | c);
    logic [8:0] col = 9'(40 + c);
    logic [1:0] m;
    setmode(blc, cl);
    cmd(C_ACT, bank, row); step();
    chk("R3 activate opens bank", 32'(bank_open), 32'(4'b1 << bank));
    cmd(w ? C_WR : C_RD, bank, {1'b0, 1'(ap), 1'b0, col}); dqm = pat(0, seed); step();
    for (int i = 0; i < bl + cl + 2; i++) begin
      bit act = i < bl;
      int k = i - cl + 1;
      chk("R5 acc_rd", 32'(acc_rd), 32'(act && w == 0));
      chk("R5 acc_wr", 32'(acc_wr), 32'(act && w == 1));
      if (act) begin
        chk("R5 column", 32'(acc_col), 32'((int'(col) & ~msk) | ((int'(col) + i) & msk)));
        chk("R3 row", 32'(acc_row), 32'(row));
        chk("R5 bank", 32'(acc_bank), 32'(bank));
      end
      m = (w == 1 && act) ? ~pat(i, seed) : 2'b00;
      chk("R6 write enable", 32'(wr_en), 32'(m));
      m = (w == 0 && k >= 0 && k < bl) ? ~pat(i - 1, seed) : 2'b00;
      chk("R7 read output enable", 32'(rd_oe), 32'(m));
      chk("R8 auto-precharge", 32'(bank_open), (ap == 1 && i >= bl) ? 32'd0 : 32'(4'b1 << bank));
      cmd(C_NOP, 2'd0, 12'd0); dqm = pat(i + 1, seed); step();
    end
    dqm = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; dqm = 2'b00;
    cmd(C_NOP, 2'd0, 12'd0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 banks idle", 32'(bank_open), 32'd0);
    chk("R1 error clear", 32'(proto_err), 32'd0);
    chk("R1 no access", 32'({acc_rd, acc_wr}), 32'd0);
    chk("R1 strobes zero", 32'({wr_en, rd_oe}), 32'd0);
    cmd(C_ACT, 2'd0, 12'h001); step();
    cmd(C_WR, 2'd0, 12'h005); step();
    chk("R4 default burst beat", 32'(acc_wr), 32'd1);
    cmd(C_NOP, 2'd0, 12'd0); step();
    chk("R4 default burst of one", 32'(acc_wr), 32'd0);

    for (int w = 0; w < 2; w++)
      for (int blc = 0; blc < 4; blc++)
        for (int cl = 2; cl < 4; cl++)
          for (int ap = 0; ap < 2; ap++)
            for (int c = 0; c < 8; c += 3)
              run_burst(w, blc, cl, ap, c);

    // R11: clock-enable freeze mid burst
    setmode(2, 2);
    cmd(C_ACT, 2'd1, 12'h007); step();
    cmd(C_WR, 2'd1, 12'h008); step();
    cmd(C_NOP, 2'd0, 12'd0); step();
    chk("R11 column before freeze", 32'(acc_col), 32'h9);
    cke = 1'b0; cmd(C_ACT, 2'd2, 12'h0AA); dqm = 2'b11; step(); step();
    chk("R11 column frozen", 32'(acc_col), 32'h9);
    chk("R11 write still active", 32'(acc_wr), 32'd1);
    chk("R11 write enable held", 32'(wr_en), 32'h3);
    chk("R11 activate ignored", 32'(bank_open), 32'h2);
    cke = 1'b1; cmd(C_NOP, 2'd0, 12'd0); dqm = 2'b00; step();
    chk("R11 resumes", 32'(acc_col), 32'hA);
    step();
    chk("R11 last beat", 32'(acc_col), 32'hB);
    step();
    chk("R11 burst ends", 32'(acc_wr), 32'd0);

    // R12: deselect during a burst
    cmd(C_RD, 2'd1, 12'h000); step();
    cs_n = 1'b1; {ras_n, cas_n, we_n} = C_PRE; addr = 12'h400; step();
    chk("R12 burst continues col", 32'(acc_col), 32'h1);
    chk("R12 burst continues rd", 32'(acc_rd), 32'd1);
    step(); step();
    chk("R12 final beat", 32'(acc_col), 32'h3);
    chk("R12 bank untouched", 32'(bank_open), 32'h2);
    step();
    chk("R12 burst done", 32'(acc_rd), 32'd0);

    // R2: deselected activate and refresh
    cs_n = 1'b1; {ras_n, cas_n, we_n} = C_ACT; ba = 2'd3; step();
    chk("R2 deselected activate", 32'(bank_open), 32'h2);
    cmd(C_REF, 2'd0, 12'h400); step();
    chk("R2 refresh no bank effect", 32'(bank_open), 32'h2);

    // R9: single and all-bank precharge
    cmd(C_ACT, 2'd0, 12'h010); step();
    cmd(C_ACT, 2'd2, 12'h020); step();
    cmd(C_ACT, 2'd3, 12'h030); step();
    chk("R9 all open", 32'(bank_open), 32'hF);
    cmd(C_PRE, 2'd2, 12'h000); step();
    chk("R9 single precharge", 32'(bank_open), 32'hB);
    cmd(C_PRE, 2'd0, 12'h400); step();
    chk("R9 precharge all", 32'(bank_open), 32'h0);
    chk("R10 no error yet", 32'(proto_err), 32'd0);

    // R10: protocol errors
    cmd(C_RD, 2'd0, 12'h000); step();
    chk("R10 read to idle bank ignored", 32'(acc_rd), 32'd0);
    chk("R10 error raised", 32'(proto_err), 32'd1);
    cmd(C_ACT, 2'd0, 12'h111); step();
    cmd(C_ACT, 2'd0, 12'h222); step();
    cmd(C_RD, 2'd0, 12'h000); step();
    chk("R10 row kept on double activate", 32'(acc_row), 32'h111);
    cmd(C_NOP, 2'd0, 12'd0); repeat (5) step();
    chk("R10 error sticky", 32'(proto_err), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule